// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Write-Through

This block places a small direct-mapped store of 32-bit words between a processor bus and a slower memory port. A read whose word is already held returns data in the same cycle it is requested, with no wait state. A read that misses is sent to memory. The fetched word is written into the selected entry and then handed to the processor. Every processor write is forwarded to memory. The cache entry for that address is refreshed, merged or dropped according to the byte enables.

Each of the 4096 entries keeps one data word, an 8-bit tag and a valid flag, which gives 16 KB of data in total. The word address is split into an entry index and a tag, and together they cover a 4 MB cacheable window. Traffic above that window goes straight to memory and never touches the cache contents. Both sides use a request/ready handshake. A flush input invalidates all entries at once.

Top module: `word_cache`

## Requirements
- R1: After reset, `cpu_ready` and `mem_req` are low, every entry is invalid, and the first read of any address goes to memory.
- R2: A read with `cpu_addr[31:22]` zero, whose entry is valid and whose stored tag equals the request tag, raises `cpu_ready` combinationally in the cycle it is presented and returns the cached word.
- R3: A read that misses issues a memory read with `mem_addr` equal to the request address with bits [1:0] cleared and `mem_be` equal to 4'b1111. `cpu_ready` rises one cycle after the cycle in which `mem_req` and `mem_ready` are both high. The word returned is the memory word, and it fills the entry so that the next read of that word hits.
- R4: The entry index is `cpu_addr[13:2]` and the tag is `cpu_addr[21:14]`. Bits [1:0] do not affect the lookup. Two addresses with the same index and different tags displace each other.
- R5: Every write issues a memory write with the request's word address, byte enables and data. It completes one cycle after the memory handshake and never completes with zero wait states.
- R6: A cacheable write with all four byte enables set fills the entry with the written word and the new tag.
- R7: A cacheable write with some byte enables clear, to an entry that hits, replaces only the enabled bytes of the cached word. Enable bit i selects data bits [8i+7:8i].
- R8: A cacheable partial write that misses invalidates its entry, so the previous occupant's next read goes to memory.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` keep their values into the next cycle.
- R10: A one-cycle pulse on `flush` invalidates every entry, so the next read of any address goes to memory.
- R11: An access with `cpu_addr[31:22]` nonzero bypasses the cache. Its reads never hit and do not fill, and its writes leave every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | 32 | Processor byte address |
| cpu_be | input | 4 | Processor write byte enables |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | Processor request completes this cycle |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the request this cycle |

## Verification
A read hit is due in the cycle it is presented. Any other access is due exactly two cycles plus the memory latency after it is presented: one cycle to register the memory request, the latency itself, and one cycle after the handshake. The bench model predicts hit or miss and the data for each access from its own copy of valid flags, tags and words. It samples `cpu_ready` one nanosecond after each falling edge and requires it to stay low in every cycle before the predicted one and to be high in that cycle. The memory model checks the request fields for stability in each waiting cycle, and the latency is varied so that both the zero-latency and the multi-cycle memory paths are covered.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } wc_state_e;
endpackage

// File: rtl/wc_tag_store.sv
module wc_tag_store #(
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [INDEX_W-1:0] idx,
  input  logic [TAG_W-1:0]   tag,
  input  logic               set_en,
  input  logic               clr_en,
  output logic               hit
);
  localparam int DEPTH = 1 << INDEX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  // Tag array: plain RAM, no reset.
  always_ff @(posedge clk) begin
    if (set_en) tag_mem[idx] <= tag;
  end

  // Valid flags: bulk clear on reset or flush.
  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (set_en)  valid_q[idx] <= 1'b1;
    else if (clr_en)  valid_q[idx] <= 1'b0;
  end

  assign hit = valid_q[idx] && (tag_mem[idx] == tag);
endmodule

// File: rtl/wc_data_store.sv
module wc_data_store #(
  parameter int INDEX_W = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] idx,
  input  logic               wr_en,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << INDEX_W;
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (wr_en && wr_be[b]) words[idx][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  // Asynchronous read gives the same-cycle hit path.
  assign rd_data = words[idx];
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
  import wc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_ready,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic [INDEX_W-1:0]  lk_index,
  output logic [TAG_W-1:0]    lk_tag,
  input  logic                lk_hit,
  input  logic [DATA_W-1:0]   lk_data,
  output logic                dw_en,
  output logic [DATA_W/8-1:0] dw_be,
  output logic [DATA_W-1:0]   dw_data,
  output logic                tg_set,
  output logic                tg_clr
);
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int KEY_W  = INDEX_W + TAG_W;

  wc_state_e             state_q;
  logic                  mem_req_q, mem_we_q;
  logic [ADDR_W-1:0]     mem_addr_q;
  logic [BYTES-1:0]      mem_be_q;
  logic [DATA_W-1:0]     mem_wdata_q, rdata_q;

  logic [ADDR_W-1:0]     look_addr, look_word;
  logic                  look_cacheable, idle_hit, finish, full_be;

  // Lookup follows the live request when idle, the held one otherwise.
  assign look_addr      = (state_q == ST_IDLE) ? cpu_addr : mem_addr_q;
  assign look_word      = look_addr >> OFF_W;
  assign lk_index       = look_word[INDEX_W-1:0];
  assign lk_tag         = look_word[INDEX_W +: TAG_W];
  assign look_cacheable = ((look_word >> KEY_W) == '0);

  assign idle_hit  = (state_q == ST_IDLE) && cpu_req && !cpu_we && lk_hit && look_cacheable;
  assign cpu_ready = idle_hit || (state_q == ST_DONE);
  assign cpu_rdata = (state_q == ST_DONE) ? rdata_q : lk_data;

  assign finish  = (state_q == ST_BUSY) && mem_ready;
  assign full_be = &mem_be_q;

  assign dw_en   = finish && look_cacheable && (!mem_we_q || full_be || lk_hit);
  assign dw_be   = (mem_we_q && !full_be) ? mem_be_q : '1;
  assign dw_data = mem_we_q ? mem_wdata_q : mem_rdata;
  assign tg_set  = finish && look_cacheable && (!mem_we_q || full_be);
  assign tg_clr  = finish && look_cacheable && mem_we_q && !full_be && !lk_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_be_q    <= '0;
      mem_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req && !idle_hit) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= cpu_we;
            mem_be_q    <= cpu_we ? cpu_be : '1;
            mem_wdata_q <= cpu_wdata;
            mem_addr_q  <= (cpu_addr >> OFF_W) << OFF_W;
            state_q     <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (mem_ready) begin
            mem_req_q <= 1'b0;
            rdata_q   <= mem_rdata;
            state_q   <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_be    = mem_be_q;
  assign mem_wdata = mem_wdata_q;
endmodule

// File: rtl/word_cache.sv
module word_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ready
);
  localparam int BYTES = DATA_W / 8;

  logic [INDEX_W-1:0] lk_index;
  logic [TAG_W-1:0]   lk_tag;
  logic               lk_hit, dw_en, tg_set, tg_clr;
  logic [DATA_W-1:0]  lk_data, dw_data;
  logic [BYTES-1:0]   dw_be;

  wc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .lk_index(lk_index), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .dw_en(dw_en), .dw_be(dw_be), .dw_data(dw_data),
    .tg_set(tg_set), .tg_clr(tg_clr)
  );

  wc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .flush(flush),
    .idx(lk_index), .tag(lk_tag),
    .set_en(tg_set), .clr_en(tg_clr), .hit(lk_hit)
  );

  wc_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .idx(lk_index),
    .wr_en(dw_en), .wr_be(dw_be), .wr_data(dw_data),
    .rd_data(lk_data)
  );
endmodule

// File: rtl/word_cache_chk.sv
module word_cache_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SPAN    = 22
) (
  input logic                clk,
  input logic                rst,
  input logic                flush,
  input logic                cpu_req,
  input logic                cpu_we,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic                cpu_ready,
  input logic                mem_req,
  input logic                mem_ready,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata
);
  // Memory request fields hold while memory stalls.
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_be) && $stable(mem_wdata)));

  // Memory addresses are word aligned; the processor waits during a memory request.
  assert_mem_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_no_ready_in_flight_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // A write only completes right after a memory write handshake.
  assert_write_through_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && cpu_ready) |-> $past(mem_req && mem_ready && mem_we));

  // The first read after a flush cannot be served from the cache.
  assert_flush_miss_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && cpu_req && !cpu_we && cpu_ready) |-> $past(mem_req && mem_ready));

  // Reads outside the cacheable window always go to memory.
  assert_bypass_miss_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we && cpu_ready && ((cpu_addr >> SPAN) != '0))
      |-> $past(mem_req && mem_ready));
endmodule

bind word_cache word_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPAN(INDEX_W + TAG_W + $clog2(DATA_W/8))
) u_word_cache_chk (
  .clk(clk), .rst(rst), .flush(flush),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
);

// File: tb/word_cache_bench.sv
`timescale 1ns/1ps
module word_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int cycles = 0;

  always #2 clk = ~clk;

  word_cache u_word_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // Behavioural backing memory, keyed by word address.
  logic [31:0] backing [int unsigned];

  function automatic logic [31:0] mem_word(input logic [31:0] waddr);
    if (backing.exists(waddr)) return backing[waddr];
    return (waddr * 32'h9E37_79B1) ^ 32'h5A17_0C3E;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] be);
    logic [31:0] r = old_w;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory-side responder: latency counted in cycles after the request is seen.
  int          mcnt = 0;
  logic        cap_we;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;

  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      mcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      mcnt = 0;
    end else if (mem_req) begin
      if (mcnt == 0) begin
        cap_we = mem_we; cap_addr = mem_addr; cap_be = mem_be; cap_wdata = mem_wdata;
      end else begin
        check("R9", "held addr", mem_addr, cap_addr);
        check("R9", "held we/be", {27'd0, mem_we, mem_be}, {27'd0, cap_we, cap_be});
        check("R9", "held wdata", mem_wdata, cap_wdata);
      end
      if (mcnt >= lat) begin
        mem_ready = 1'b1;
        if (cap_we) backing[cap_addr >> 2] = merge(mem_word(cap_addr >> 2), cap_wdata, cap_be);
        else mem_rdata = mem_word(cap_addr >> 2);
      end else begin
        mcnt++;
      end
    end
  end

  // Reference cache state.
  bit          rv [4096];
  bit [7:0]    rt [4096];
  bit [31:0]   rdw [4096];

  task automatic xfer(input string req, input bit we, input logic [31:0] addr,
                      input logic [3:0] be, input logic [31:0] wd);
    int idx = int'(addr[13:2]);
    bit inr = (addr[31:22] == 0);
    bit hit = inr && rv[idx] && (rt[idx] == addr[21:14]);
    int exp_w = (!we && hit) ? 0 : lat + 2;
    logic [31:0] exp_d = hit ? rdw[idx] : mem_word(addr >> 2);
    int w;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
    for (w = 0; w < 64; w++) begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
    end
    check(req, we ? "write wait cycles" : "read wait cycles", w, exp_w);
    if (!we) check(req, "read data", cpu_rdata, exp_d);
    if (exp_w != 0) begin
      check(req, "mem addr", cap_addr, {addr[31:2], 2'b00});
      check(req, "mem we/be", {27'd0, cap_we, cap_be}, {27'd0, we, we ? be : 4'hF});
      if (we) check(req, "mem wdata", cap_wdata, wd);
    end
    // Update reference cache.
    if (inr) begin
      if (!we) begin
        rv[idx] = 1; rt[idx] = addr[21:14]; rdw[idx] = exp_d;
      end else if (be == 4'hF) begin
        rv[idx] = 1; rt[idx] = addr[21:14]; rdw[idx] = wd;
      end else if (hit) begin
        rdw[idx] = merge(rdw[idx], wd, be);
      end else begin
        rv[idx] = 0;
      end
    end
  endtask

  task automatic rd(input string req, input logic [31:0] addr);
    xfer(req, 1'b0, addr, 4'hF, 32'h0);
  endtask

  task automatic wr(input string req, input logic [31:0] addr, input logic [3:0] be,
                    input logic [31:0] wd);
    xfer(req, 1'b1, addr, be, wd);
  endtask

  task automatic do_flush();
    @(negedge clk);
    cpu_req = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 4096; i++) rv[i] = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) rv[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "cpu_ready after reset", {31'd0, cpu_ready}, 32'd0);
    check("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);

    lat = 1;
    rd("R1", 32'h0000_0100);              // first read misses
    rd("R2", 32'h0000_0100);              // same word now hits
    rd("R4", 32'h0000_0103);              // byte offset ignored
    rd("R4", 32'h0000_4100);              // same index, new tag
    rd("R4", 32'h0000_0100);              // displaced, misses again
    rd("R3", 32'h0000_0100);              // refilled, hits

    wr("R5", 32'h0000_0200, 4'hF, 32'hDEAD_BEEF);
    rd("R6", 32'h0000_0200);

    lat = 3;
    wr("R7", 32'h0000_0200, 4'b0011, 32'h1234_5678);
    rd("R7", 32'h0000_0200);              // merged word, hit
    wr("R8", 32'h0000_4200, 4'b0100, 32'h00AB_0000);
    rd("R8", 32'h0000_0200);              // entry was invalidated
    rd("R8", 32'h0000_4200);

    rd("R11", 32'h0000_0100);
    rd("R11", 32'h0040_0100);             // aliases index/tag of 0x100
    rd("R11", 32'h0040_0100);             // still not cached
    rd("R11", 32'h0000_0100);             // original still hits
    wr("R11", 32'h0040_0100, 4'hF, 32'hCAFE_F00D);
    rd("R11", 32'h0000_0100);             // unchanged by bypass write

    lat = 0;
    do_flush();
    rd("R10", 32'h0000_0100);             // misses after flush
    rd("R10", 32'h0000_0200);
    rd("R10", 32'h0000_0100);

    lat = 2;
    for (int i = 0; i < 8; i++) wr("R6", 32'h0000_1000 + 32'(4 * i), 4'hF, 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) rd("R2", 32'h0000_1000 + 32'(4 * i));
    for (int i = 0; i < 4; i++) rd("R4", 32'h003F_C000 + 32'h0000_1000 + 32'(4 * i));
    for (int i = 0; i < 4; i++) rd("R4", 32'h0000_1000 + 32'(4 * i));

    @(negedge clk);
    cpu_req = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule